// File: doc/BRIEF.md
# Predicated Execution Gate with Condition Evaluation

This unit decides, once per issued instruction, whether that instruction is allowed to take effect. It holds the architectural flag state (negative, zero, carry, overflow) and tests it against the 4-bit condition field carried by the instruction. The pass decision then qualifies three requests that come from the execute stage: the result register write, the flag update and the branch. A held condition lets all three through. A failed condition blocks all three, and the instruction still occupies its single cycle.

Because the flags change only when a flag-updating instruction passes its condition, compares can be chained. A compare guarded by a condition rewrites the flags only when the earlier compare left that condition true. The program counter selector returns the branch target for a branch that passes and the sequential address otherwise. Decoding, fetch and the arithmetic itself happen outside the unit.

Top module: `pred_unit`

## Requirements
- R1: Synchronous active-high reset clears the held flags: `flags` reads 4'b0000. Flag bit order is N at bit 3, Z at bit 2, C at bit 1 and V at bit 0, for both `flags` and `alu_flags`.
- R2: Code 0 passes when Z=1. Code 1 passes when Z=0.
- R3: Code 2 passes when C=1. Code 3 passes when C=0.
- R4: Code 4 passes when N=1 and code 5 passes when N=0. Code 6 passes when V=1 and code 7 passes when V=0.
- R5: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R6: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R7: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R8: Codes 14 and 15 pass for every flag value.
- R9: `wr_en` is high exactly when `issue_valid`, `wr_req` and `pass` are all high in the same cycle.
- R10: At the clock edge, `flags` loads `alu_flags` only when `issue_valid`, `flag_req` and `pass` are all high. In every other case `flags` keeps its value, so a compare whose condition fails leaves the flags untouched. `flag_we` shows this load enable.
- R11: `branch_taken` is high when `issue_valid`, `branch_req` and `pass` are all high. In that case `next_pc` equals `target`; otherwise `next_pc` equals `pc` + 4.
- R12: `pass` and the gated outputs are combinational from the held flags and the current inputs. Every issued instruction is resolved in the cycle it is presented, whatever its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| cond | input | 4 | Condition code of the instruction |
| wr_req | input | 1 | Instruction wants to write its result register |
| flag_req | input | 1 | Instruction wants to update the flags |
| branch_req | input | 1 | Instruction is a branch |
| alu_flags | input | 4 | New N,Z,C,V produced by the execute stage |
| pc | input | 32 | Address of the current instruction |
| target | input | 32 | Branch target address |
| pass | output | 1 | Condition holds for the held flags |
| wr_en | output | 1 | Gated result write enable |
| flag_we | output | 1 | Gated flag update enable |
| branch_taken | output | 1 | Branch redirects the program counter |
| next_pc | output | 32 | Address of the next instruction |
| flags | output | 4 | Held N,Z,C,V state |

## Verification
The only storage is the flag register, and an error in it becomes visible at the ports in the next cycle. `flags` shows the wrong value directly, and every later `pass` decision is based on that wrong state. A flag load that is missed or spurious after a failed conditional compare therefore appears within one cycle on `flags`, and on `pass` for the following instruction. A wrong condition mapping shows up at once on `pass` and on the three gated enables for the specific pairing of flags and code. For this reason the sweep first loads every one of the 16 flag values and then tries every one of the 16 codes against it.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int FLAG_W = 4;
    localparam int COND_W = 4;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,
        CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,
        CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,
        CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13,
        CC_AL = 4'd14, CC_XX = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Base test for an even/odd code pair; the odd code is its complement.
    function automatic logic pair_test(input logic [2:0] pair, input nzcv_t f);
        case (pair)
            3'd0:    pair_test = f.z;
            3'd1:    pair_test = f.c;
            3'd2:    pair_test = f.n;
            3'd3:    pair_test = f.v;
            3'd4:    pair_test = f.c & ~f.z;
            3'd5:    pair_test = ~(f.n ^ f.v);
            3'd6:    pair_test = ~f.z & ~(f.n ^ f.v);
            default: pair_test = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
    import pred_pkg::*;
(
    input  nzcv_t              flags_i,
    input  logic [COND_W-1:0]  cond_i,
    output logic               pass_o
);
    logic [2:0] pair;
    logic       base;
    logic       invert;

    always_comb begin
        pair   = cond_i[COND_W-1:1];
        base   = pair_test(pair, flags_i);
        // The always pair (14, 15) is never inverted.
        invert = cond_i[0] & (pair != 3'd7);
        pass_o = base ^ invert;
    end
endmodule

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
    import pred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  nzcv_t d_i,
    output nzcv_t q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/pred_pc_sel.sv
module pred_pc_sel #(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              taken_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    always_comb begin
        next_pc_o = taken_i ? target_i : (pc_i + STEP);
    end
endmodule

// File: rtl/pred_unit.sv
module pred_unit
    import pred_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [3:0]        cond,
    input  logic              wr_req,
    input  logic              flag_req,
    input  logic              branch_req,
    input  logic [3:0]        alu_flags,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              pass,
    output logic              wr_en,
    output logic              flag_we,
    output logic              branch_taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [3:0]        flags
);
    nzcv_t cur_flags;
    logic  go;

    pred_cond_eval u_eval (
        .flags_i (cur_flags),
        .cond_i  (cond),
        .pass_o  (pass)
    );

    always_comb begin
        go           = issue_valid & pass;
        wr_en        = go & wr_req;
        flag_we      = go & flag_req;
        branch_taken = go & branch_req;
        flags        = cur_flags;
    end

    pred_flag_reg u_flags (
        .clk    (clk),
        .rst    (rst),
        .load_i (flag_we),
        .d_i    (nzcv_t'(alu_flags)),
        .q_o    (cur_flags)
    );

    pred_pc_sel #(
        .ADDR_W  (ADDR_W),
        .PC_STEP (PC_STEP)
    ) u_pc (
        .pc_i      (pc),
        .target_i  (target),
        .taken_i   (branch_taken),
        .next_pc_o (next_pc)
    );
endmodule

// File: rtl/pred_unit_chk.sv
module pred_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic [3:0]        cond,
    input logic              wr_req,
    input logic              flag_req,
    input logic              branch_req,
    input logic [3:0]        alu_flags,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] target,
    input logic              pass,
    input logic              wr_en,
    input logic              flag_we,
    input logic              branch_taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic [3:0]        flags
);
    localparam logic [ADDR_W-1:0] STEP4 = ADDR_W'(4);

    // R10: flags hold unless a passing flag update was issued
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(issue_valid && flag_req && pass) |=> $stable(flags));

    // R10: a passing flag update loads the execute-stage flags
    assert_flags_load_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && flag_req && pass) |=> flags == $past(alu_flags));

    // R9: write enable only for an issued, passing writer
    assert_wr_gate_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (issue_valid && wr_req && pass));

    // R11: sequential address when no branch is taken
    assert_seq_pc_R11: assert property (@(posedge clk) disable iff (rst)
        !branch_taken |-> next_pc == pc + STEP4);

    // R11: target address when a branch is taken
    assert_tgt_pc_R11: assert property (@(posedge clk) disable iff (rst)
        branch_taken |-> (next_pc == target && issue_valid && branch_req));

    // R8: always codes never fail
    assert_always_R8: assert property (@(posedge clk) disable iff (rst)
        (cond[3:1] == 3'd7) |-> pass);

    // R6: signed greater-or-equal follows N and V of the held flags
    assert_signed_ge_R6: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'd10) |-> pass == (flags[3] == flags[0]));

    // R10: flag_we agrees with the request and the decision
    assert_flag_we_R10: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> (issue_valid && flag_req && pass));
endmodule

bind pred_unit pred_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .issue_valid  (issue_valid),
    .cond         (cond),
    .wr_req       (wr_req),
    .flag_req     (flag_req),
    .branch_req   (branch_req),
    .alu_flags    (alu_flags),
    .pc           (pc),
    .target       (target),
    .pass         (pass),
    .wr_en        (wr_en),
    .flag_we      (flag_we),
    .branch_taken (branch_taken),
    .next_pc      (next_pc),
    .flags        (flags)
);

// File: tb/pred_unit_tb.sv
module pred_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [3:0]  cond = 4'd0;
    logic        wr_req = 1'b0;
    logic        flag_req = 1'b0;
    logic        branch_req = 1'b0;
    logic [3:0]  alu_flags = 4'd0;
    logic [31:0] pc = 32'd0;
    logic [31:0] target = 32'd0;
    logic        pass, wr_en, flag_we, branch_taken;
    logic [31:0] next_pc;
    logic [3:0]  flags;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pred_unit u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .cond(cond),
        .wr_req(wr_req), .flag_req(flag_req), .branch_req(branch_req),
        .alu_flags(alu_flags), .pc(pc), .target(target), .pass(pass),
        .wr_en(wr_en), .flag_we(flag_we), .branch_taken(branch_taken),
        .next_pc(next_pc), .flags(flags)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected decision worked out from the requirement text, flags {N,Z,C,V}.
    function automatic bit want(input int code, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        bit sge = (n == v);
        case (code)
            0:  return z;            // R2
            1:  return !z;           // R2
            2:  return c;            // R3
            3:  return !c;           // R3
            4:  return n;            // R4
            5:  return !n;           // R4
            6:  return v;            // R4
            7:  return !v;           // R4
            8:  return c && !z;      // R5
            9:  return !c || z;      // R5
            10: return sge;          // R6
            11: return !sge;         // R6
            12: return !z && sge;    // R7
            13: return z || !sge;    // R7
            default: return 1'b1;    // R8
        endcase
    endfunction

    function automatic string tag(input int code);
        case (code)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5, 6, 7: return "R4";
            8, 9: return "R5";
            10, 11: return "R6";
            12, 13: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(flags == 4'b0000, "R1 reset flags", {28'd0, flags}, 32'd0);

        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] fv;
                logic [3:0] nf;
                bit e;
                fv = 4'(f);
                nf = ~fv;
                // Load the flags with an always-passing update.
                @(negedge clk);
                issue_valid = 1'b1; cond = 4'd14; flag_req = 1'b1;
                wr_req = 1'b0; branch_req = 1'b0; alu_flags = fv;
                @(negedge clk);
                chk(flags == fv, "R10 load", {28'd0, flags}, {28'd0, fv});
                // Issue the gated instruction under test.
                pc = {22'(c * 16 + f), 10'h0};
                target = pc ^ 32'h8000_0010;
                cond = 4'(c); wr_req = 1'b1; flag_req = 1'b1;
                branch_req = 1'b1; alu_flags = nf;
                #1;
                e = want(c, fv);
                chk(pass == e, {tag(c), " pass R12"}, {31'd0, pass}, {31'd0, e});
                chk(wr_en == e, "R9 wr_en", {31'd0, wr_en}, {31'd0, e});
                chk(branch_taken == e, "R11 taken", {31'd0, branch_taken}, {31'd0, e});
                chk(next_pc == (e ? target : pc + 32'd4), "R11 next_pc",
                    next_pc, e ? target : pc + 32'd4);
                @(negedge clk);
                chk(flags == (e ? nf : fv), "R10 chained update",
                    {28'd0, flags}, {28'd0, e ? nf : fv});
            end
        end

        // No instruction issued: nothing may take effect.
        @(negedge clk);
        issue_valid = 1'b0; cond = 4'd14; wr_req = 1'b1; flag_req = 1'b1;
        branch_req = 1'b1; alu_flags = ~flags; pc = 32'h100; target = 32'h4000;
        begin
            logic [3:0] held;
            held = flags;
            #1;
            chk(wr_en == 1'b0, "R9 idle wr_en", {31'd0, wr_en}, 32'd0);
            chk(next_pc == 32'h104, "R11 idle next_pc", next_pc, 32'h104);
            @(negedge clk);
            chk(flags == held, "R10 idle hold", {28'd0, flags}, {28'd0, held});
        end

        // Reset again clears flags.
        alu_flags = 4'hF; issue_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(flags == 4'b0000, "R1 re-reset", {28'd0, flags}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule